// File: doc/BRIEF.md
# I2C Slave Controller with Software Handshake

This block is the target side of an I2C bus, run by a processor through four byte-wide registers: control, status, data and own address. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It compares the first byte after a START with a programmed 7-bit address and, when enabled, with the general call address. It then receives or transmits data bytes, depending on the direction bit.

After every significant bus event the block raises an interrupt flag and loads an 8-bit status code. For byte events it holds SCL low until software writes 0 to the flag, so the master waits while software reads or supplies the next data byte. Whether the block acknowledges an address or a received byte is controlled by a software bit. The block has no master function and no bit-rate generator.

Top module: `i2cs_slave`

## Requirements
- R1: After reset, irq is low, neither bus line is driven, the control, own-address and data registers read 0x00 and status reads 0xF8.
- R2: Control register (sel 0): bit 6 enable, bit 5 start request, bit 4 stop request, bit 3 interrupt flag, bit 2 acknowledge enable, bit 0 rate select. Bits 7 and 1 read 0. Start request, stop request and rate select are stored and read back but have no effect on slave traffic. Writing 1 to bit 3 never sets the flag; only bus events set it.
- R3: Own-address register (sel 3) bits 7:1 hold the address. A matching address byte with direction 0 is acknowledged (SDA low in the 9th clock), sets the flag with status 0x60, and SCL is held low from the end of the 9th clock while the flag is set.
- R4: Own-address bit 0 enables general call. Byte 0x00 is then acknowledged with status 0x70; with bit 0 clear it is not acknowledged and the flag stays low.
- R5: With acknowledge enable at 0, or on an address that does not match, the address byte is not acknowledged, the flag stays low and the block ignores the bus until the next START.
- R6: In receive mode each byte is placed in the data register (sel 2). With acknowledge enable at 1 it is acknowledged with status 0x80. With acknowledge enable at 0 it is not acknowledged, status is 0x88 and the block ignores later bytes until the next START.
- R7: A matching address with direction 1 is acknowledged with status 0x A8 written as 0xA8; the block then sends the data register MSB first, with SDA changing only while SCL is low.
- R8: After a sent byte, a master ACK gives status 0xB8 and the next byte follows. A master NACK gives status 0xC0 and the block stops driving SDA.
- R9: A STOP or repeated START while addressed sets the flag with status 0xA0 without holding SCL. After a repeated START the block can be addressed again.
- R10: Status (sel 1) reads 0xF8 whenever the flag is clear.
- R11: Writing the control register with bit 3 at 0 clears the flag in the next cycle and releases SCL.
- R12: With enable at 0 the block drives neither line and raises no flag for any traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or data 0) |

## Verification
The assertions assume a well-formed bus: SDA changes only while SCL is low, except to form START and STOP. They also assume the SCL low phase is long enough for the synchronizer and the flag register to settle. They further assume software leaves the data and control registers alone while SCL is high in a transmit byte. The bench master changes SDA a few cycles after it sees SCL low, keeps half periods at 16 clocks, waits for SCL to read high before it counts a high phase, and issues every register write while the bus is stretched or idle.

// File: rtl/i2cs_pkg.sv
// Shared constants and types for the I2C slave controller.
// Assumes a byte-wide register file addressed by a 2-bit select.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam int SEL_W  = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DATA = 2'd2;
    localparam logic [SEL_W-1:0] SEL_OWN  = 2'd3;

    localparam int CB_EN   = 6;
    localparam int CB_STA  = 5;
    localparam int CB_STO  = 4;
    localparam int CB_FLAG = 3;
    localparam int CB_ACK  = 2;
    localparam int CB_RATE = 0;

    localparam logic [7:0] CODE_NONE    = 8'hF8;
    localparam logic [7:0] CODE_SW_ADDR = 8'h60;
    localparam logic [7:0] CODE_GC_ADDR = 8'h70;
    localparam logic [7:0] CODE_RX_ACK  = 8'h80;
    localparam logic [7:0] CODE_RX_NACK = 8'h88;
    localparam logic [7:0] CODE_END     = 8'hA0;
    localparam logic [7:0] CODE_SR_ADDR = 8'hA8;
    localparam logic [7:0] CODE_TX_ACK  = 8'hB8;
    localparam logic [7:0] CODE_TX_NACK = 8'hC0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_t;
endpackage

// File: rtl/i2cs_bus_mon.sv
// Bus monitor: synchronizes SCL and SDA and flags START, STOP and SCL edges.
// Assumes SYNC_STAGES >= 2; the lines idle high, so the pipes reset to 1.
module i2cs_bus_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic fall_p
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_prev;
    logic          sda_prev;

    // Shift both lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[LAST];
    assign sda_s = sda_pipe[LAST];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign start_p = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_p  = scl_s && scl_prev && !sda_prev && sda_s;
    assign rise_p  = scl_s && !scl_prev;
    assign fall_p  = !scl_s && scl_prev;
endmodule

// File: rtl/i2cs_engine.sv
// Transfer engine: address match, byte shifting, ACK handling and event codes.
// Assumes one-cycle condition pulses from the bus monitor; reports each
// event as a one-cycle ev_set with a code and a hold request for SCL.
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ack_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic [BYTE_W-1:0] data_q,
    input  logic              sda_s,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              rise_p,
    input  logic              fall_p,
    output logic              ev_set,
    output logic              ev_hold,
    output logic [7:0]        ev_code,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_low
);
    phase_t             phase;
    logic [CNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]  shreg;
    logic               dir_rd;
    logic               gc_hit;
    logic               ackd;
    logic               mnack;
    logic               addressed;
    logic               hit_own;
    logic               hit_gc;
    logic [IDX_W-1:0]   tx_idx;

    // Decode address hits and the transmit bit index.
    always_comb begin
        addressed = (phase == PH_RX) || (phase == PH_RX_ACK) ||
                    (phase == PH_TX) || (phase == PH_TX_ACK);
        hit_own   = (shreg[BYTE_W-1:1] == own_addr);
        hit_gc    = gc_en && (shreg == '0);
        tx_idx    = IDX_W'(BYTE_W - 1) - bitcnt[IDX_W-1:0];
    end

    // Advance the transfer phase on bus conditions and SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            dir_rd  <= 1'b0;
            gc_hit  <= 1'b0;
            ackd    <= 1'b0;
            mnack   <= 1'b0;
            ev_set  <= 1'b0;
            ev_hold <= 1'b0;
            ev_code <= CODE_NONE;
            rx_load <= 1'b0;
        end else begin
            ev_set  <= 1'b0;
            rx_load <= 1'b0;
            if (!en) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
            end else if (start_p) begin
                if (addressed) begin
                    ev_set  <= 1'b1;
                    ev_hold <= 1'b0;
                    ev_code <= CODE_END;
                end
                phase  <= PH_ADDR;
                bitcnt <= '0;
            end else if (stop_p) begin
                if (addressed) begin
                    ev_set  <= 1'b1;
                    ev_hold <= 1'b0;
                    ev_code <= CODE_END;
                end
                phase <= PH_IDLE;
            end else if (rise_p) begin
                case (phase)
                    PH_ADDR, PH_RX: begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end
                    PH_TX_ACK: mnack <= sda_s;
                    default: ;
                endcase
            end else if (fall_p) begin
                case (phase)
                    PH_ADDR: begin
                        if (bitcnt == CNT_W'(BYTE_W)) begin
                            if ((hit_own || hit_gc) && ack_en) begin
                                phase  <= PH_ADDR_ACK;
                                dir_rd <= shreg[0];
                                gc_hit <= hit_gc;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        ev_set  <= 1'b1;
                        ev_hold <= 1'b1;
                        ev_code <= gc_hit ? CODE_GC_ADDR :
                                   (dir_rd ? CODE_SR_ADDR : CODE_SW_ADDR);
                        phase   <= dir_rd ? PH_TX : PH_RX;
                        bitcnt  <= '0;
                    end
                    PH_RX: begin
                        if (bitcnt == CNT_W'(BYTE_W)) begin
                            phase <= PH_RX_ACK;
                            ackd  <= ack_en;
                        end
                    end
                    PH_RX_ACK: begin
                        rx_load <= 1'b1;
                        ev_set  <= 1'b1;
                        ev_hold <= 1'b1;
                        ev_code <= ackd ? CODE_RX_ACK : CODE_RX_NACK;
                        phase   <= ackd ? PH_RX : PH_IDLE;
                        bitcnt  <= '0;
                    end
                    PH_TX: begin
                        if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                            phase <= PH_TX_ACK;
                        end
                        bitcnt <= bitcnt + CNT_W'(1);
                    end
                    PH_TX_ACK: begin
                        ev_set  <= 1'b1;
                        ev_hold <= 1'b1;
                        ev_code <= mnack ? CODE_TX_NACK : CODE_TX_ACK;
                        phase   <= mnack ? PH_IDLE : PH_TX;
                        bitcnt  <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rx_byte = shreg;

    // Pull SDA low for acknowledges and for transmitted zero bits.
    always_comb begin
        sda_low = en && ((phase == PH_ADDR_ACK) ||
                         ((phase == PH_RX_ACK) && ackd) ||
                         ((phase == PH_TX) && !data_q[tx_idx]));
    end
endmodule

// File: rtl/i2cs_regs.sv
// Register file: control, status, data and own address, plus the flag.
// Assumes hardware events win over a same-cycle software write.
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ev_set,
    input  logic              ev_hold,
    input  logic [7:0]        ev_code,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              en,
    output logic              ack_en,
    output logic [ADDR_W-1:0] own_addr,
    output logic              gc_en,
    output logic [BYTE_W-1:0] data_q,
    output logic              flag,
    output logic              hold
);
    logic              sta_q;
    logic              sto_q;
    logic              rate_q;
    logic [BYTE_W-1:0] own_q;
    logic [7:0]        code_q;
    logic              wr_ctrl;

    assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);

    // Store the software-written control and address fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            sta_q  <= 1'b0;
            sto_q  <= 1'b0;
            ack_en <= 1'b0;
            rate_q <= 1'b0;
            own_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en     <= reg_wdata[CB_EN];
                sta_q  <= reg_wdata[CB_STA];
                sto_q  <= reg_wdata[CB_STO];
                ack_en <= reg_wdata[CB_ACK];
                rate_q <= reg_wdata[CB_RATE];
            end
            if (reg_we && (reg_sel == SEL_OWN)) begin
                own_q <= reg_wdata;
            end
        end
    end

    // Data register: a received byte overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rx_load) begin
            data_q <= rx_byte;
        end else if (reg_we && (reg_sel == SEL_DATA)) begin
            data_q <= reg_wdata;
        end
    end

    // Flag, hold and status code: set by events, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            hold   <= 1'b0;
            code_q <= CODE_NONE;
        end else if (ev_set) begin
            flag   <= 1'b1;
            hold   <= ev_hold;
            code_q <= ev_code;
        end else if (wr_ctrl && !reg_wdata[CB_FLAG]) begin
            flag <= 1'b0;
            hold <= 1'b0;
        end
    end

    assign own_addr = own_q[BYTE_W-1:1];
    assign gc_en    = own_q[0];

    // Read multiplexer for the selected register.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {1'b0, en, sta_q, sto_q, flag, ack_en, 1'b0, rate_q};
            SEL_STAT: reg_rdata = flag ? code_q : CODE_NONE;
            SEL_DATA: reg_rdata = data_q;
            default:  reg_rdata = own_q;
        endcase
    end
endmodule

// File: rtl/i2cs_slave.sv
// I2C slave controller top: bus monitor, transfer engine and registers.
// Assumes clk runs at least about eight times faster than SCL.
module i2cs_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    logic              scl_s;
    logic              sda_s;
    logic              start_p;
    logic              stop_p;
    logic              rise_p;
    logic              fall_p;
    logic              en;
    logic              ack_en;
    logic [ADDR_W-1:0] own_addr;
    logic              gc_en;
    logic [BYTE_W-1:0] data_q;
    logic              flag;
    logic              hold;
    logic              ev_set;
    logic              ev_hold;
    logic [7:0]        ev_code;
    logic              rx_load;
    logic [BYTE_W-1:0] rx_byte;

    i2cs_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_p (start_p),
        .stop_p  (stop_p),
        .rise_p  (rise_p),
        .fall_p  (fall_p)
    );

    i2cs_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ack_en   (ack_en),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .data_q   (data_q),
        .sda_s    (sda_s),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .ev_set   (ev_set),
        .ev_hold  (ev_hold),
        .ev_code  (ev_code),
        .rx_load  (rx_load),
        .rx_byte  (rx_byte),
        .sda_low  (sda_drive_low)
    );

    i2cs_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_set    (ev_set),
        .ev_hold   (ev_hold),
        .ev_code   (ev_code),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .en        (en),
        .ack_en    (ack_en),
        .own_addr  (own_addr),
        .gc_en     (gc_en),
        .data_q    (data_q),
        .flag      (flag),
        .hold      (hold)
    );

    assign irq           = flag;
    assign scl_drive_low = en && flag && hold;
endmodule

// File: rtl/i2cs_slave_chk.sv
// Property checker for the I2C slave, bound into the top module.
// Assumes a well-formed bus and register writes only while SCL is low or idle.
module i2cs_slave_chk
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              irq,
    input logic              scl_drive_low,
    input logic              sda_drive_low,
    input logic              en,
    input logic              scl_s,
    input logic              ev_set
);
    // R11
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_sel == SEL_CTRL) && !reg_wdata[CB_FLAG] && !ev_set) |=> !irq);

    // R2
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_set));

    // R3
    stretch_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> !scl_s);

    // R7
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(reg_we)) |-> $stable(sda_drive_low));

    // R12
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!scl_drive_low && !sda_drive_low));
endmodule

bind i2cs_slave i2cs_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .irq           (irq),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .en            (en),
    .scl_s         (scl_s),
    .ev_set        (ev_set)
);

// File: tb/i2cs_slave_tb.sv
// Bench for the I2C slave: a bus master model with clock-stretch support,
// directed corner cases and seeded random transfers.
module i2cs_slave_tb;
    import i2cs_pkg::*;

    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       scl_drive_low;
    logic       sda_drive_low;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    wire        scl_line = scl_m & ~scl_drive_low;
    wire        sda_line = sda_m & ~sda_drive_low;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ctrl_sh = 8'h00;

    always #10 clk = ~clk;

    i2cs_slave u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq),
        .scl_i         (scl_line),
        .sda_i         (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low)
    );

    function automatic logic [7:0] exp_addr_code(input logic rd, input logic gc);
        if (gc) return 8'h70;
        return rd ? 8'hA8 : 8'h60;
    endfunction

    function automatic logic [7:0] exp_tx_code(input logic master_ack);
        return master_ack ? 8'hB8 : 8'hC0;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel == SEL_CTRL) ctrl_sh = val & 8'hF7;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic clear_flag();
        reg_write(SEL_CTRL, ctrl_sh);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_cyc(4);
        scl_up(); wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(4);
        scl_up(); wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_cyc(4);
        scl_up(); wait_cyc(H);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic recv_bit(output logic v);
        sda_m = 1'b1; wait_cyc(4);
        scl_up(); wait_cyc(H / 2);
        v = sda_line; wait_cyc(H / 2);
        scl_m = 1'b0; wait_cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v);
        acked = ~v;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v);
            b[i] = v;
        end
        send_bit(~give_ack);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       ack;
        logic [7:0] b;
        logic [7:0] got;
        int unsigned seed_v;
        seed_v = $urandom(32'd1357);

        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 drive", {6'd0, scl_drive_low, sda_drive_low}, 8'h00);
        reg_read(SEL_STAT, rd); check("R1 status", rd, 8'hF8);
        reg_read(SEL_CTRL, rd); check("R1 ctrl", rd, 8'h00);
        reg_read(SEL_OWN, rd);  check("R1 own", rd, 8'h00);
        reg_read(SEL_DATA, rd); check("R1 data", rd, 8'h00);

        // R2: control layout, flag not settable by software
        reg_write(SEL_CTRL, 8'hFF);
        reg_read(SEL_CTRL, rd); check("R2 ctrl readback", rd, 8'h75);
        check("R2 irq not set by write", {7'd0, irq}, 8'h00);
        reg_write(SEL_CTRL, 8'h75);
        reg_write(SEL_OWN, {7'h5A, 1'b1});

        // R3: own address write, stretch while flag set
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        check("R3 address ack", {7'd0, ack}, 8'h01);
        check("R3 irq", {7'd0, irq}, 8'h01);
        reg_read(SEL_STAT, rd); check("R3 status", rd, 8'h60);
        wait_cyc(3);
        check("R3 scl held", {7'd0, scl_drive_low}, 8'h01);
        clear_flag();
        check("R11 scl released", {7'd0, scl_drive_low}, 8'h00);
        check("R11 irq cleared", {7'd0, irq}, 8'h00);
        reg_read(SEL_STAT, rd); check("R10 status idle", rd, 8'hF8);

        // R6: received bytes with acknowledge
        for (int k = 0; k < 3; k++) begin
            b = 8'($urandom);
            send_byte(b, ack);
            check("R6 rx ack", {7'd0, ack}, 8'h01);
            reg_read(SEL_STAT, rd); check("R6 rx status", rd, 8'h80);
            reg_read(SEL_DATA, rd); check("R6 rx data", rd, b);
            clear_flag();
        end
        // R9: stop while addressed
        bus_stop();
        check("R9 stop irq", {7'd0, irq}, 8'h01);
        reg_read(SEL_STAT, rd); check("R9 stop status", rd, 8'hA0);
        check("R9 stop no stretch", {7'd0, scl_drive_low}, 8'h00);
        clear_flag();

        // R4: general call enabled
        bus_start();
        send_byte(8'h00, ack);
        check("R4 gc ack", {7'd0, ack}, 8'h01);
        reg_read(SEL_STAT, rd); check("R4 gc status", rd, 8'h70);
        clear_flag();
        send_byte(8'h3C, ack);
        reg_read(SEL_STAT, rd); check("R4 gc data status", rd, 8'h80);
        clear_flag();
        bus_stop();
        clear_flag();

        // R4: general call disabled
        reg_write(SEL_OWN, {7'h5A, 1'b0});
        bus_start();
        send_byte(8'h00, ack);
        check("R4 gc off nack", {7'd0, ack}, 8'h00);
        check("R4 gc off irq", {7'd0, irq}, 8'h00);
        bus_stop();
        check("R4 gc off stop irq", {7'd0, irq}, 8'h00);

        // R5: acknowledge disabled, then mismatching address
        reg_write(SEL_CTRL, 8'h41);
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        check("R5 ack off nack", {7'd0, ack}, 8'h00);
        check("R5 ack off irq", {7'd0, irq}, 8'h00);
        bus_stop();
        reg_write(SEL_CTRL, 8'h44);
        bus_start();
        send_byte({7'h22, 1'b0}, ack);
        check("R5 mismatch nack", {7'd0, ack}, 8'h00);
        send_byte(8'h00, ack);
        check("R5 ignored byte", {6'd0, ack, irq}, 8'h00);
        bus_stop();

        // R6: receive with acknowledge disabled
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        reg_write(SEL_CTRL, 8'h40);
        send_byte(8'hC3, ack);
        check("R6 nack byte", {7'd0, ack}, 8'h00);
        reg_read(SEL_STAT, rd); check("R6 nack status", rd, 8'h88);
        reg_read(SEL_DATA, rd); check("R6 nack data", rd, 8'hC3);
        clear_flag();
        send_byte(8'h5A, ack);
        check("R6 later byte ignored", {6'd0, ack, irq}, 8'h00);
        reg_read(SEL_DATA, rd); check("R6 data kept", rd, 8'hC3);
        bus_stop();
        check("R6 no stop event", {7'd0, irq}, 8'h00);

        // R7, R8: transmit with ACK then NACK
        reg_write(SEL_CTRL, 8'h44);
        reg_write(SEL_DATA, 8'hA6);
        bus_start();
        send_byte({7'h5A, 1'b1}, ack);
        check("R7 read ack", {7'd0, ack}, 8'h01);
        reg_read(SEL_STAT, rd); check("R7 read status", rd, 8'hA8);
        clear_flag();
        recv_byte(1'b1, got);
        check("R7 tx byte", got, 8'hA6);
        reg_read(SEL_STAT, rd); check("R8 tx ack status", rd, exp_tx_code(1'b1));
        reg_write(SEL_DATA, 8'h39);
        clear_flag();
        recv_byte(1'b0, got);
        check("R8 second byte", got, 8'h39);
        reg_read(SEL_STAT, rd); check("R8 tx nack status", rd, exp_tx_code(1'b0));
        clear_flag();
        recv_byte(1'b0, got);
        check("R8 released after nack", got, 8'hFF);
        bus_stop();
        check("R8 no stop event", {7'd0, irq}, 8'h00);

        // R9: repeated start while addressed, then re-addressed for read
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        clear_flag();
        send_byte(8'h11, ack);
        clear_flag();
        bus_rstart();
        check("R9 rstart irq", {7'd0, irq}, 8'h01);
        reg_read(SEL_STAT, rd); check("R9 rstart status", rd, 8'hA0);
        check("R9 rstart no stretch", {7'd0, scl_drive_low}, 8'h00);
        clear_flag();
        reg_write(SEL_DATA, 8'h0F);
        send_byte({7'h5A, 1'b1}, ack);
        reg_read(SEL_STAT, rd); check("R9 readdress status", rd, 8'hA8);
        clear_flag();
        recv_byte(1'b0, got);
        check("R9 readdress byte", got, 8'h0F);
        clear_flag();
        bus_stop();

        // R12: disabled block ignores traffic
        reg_write(SEL_CTRL, 8'h04);
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        check("R12 disabled nack", {7'd0, ack}, 8'h00);
        check("R12 disabled irq", {7'd0, irq}, 8'h00);
        bus_stop();
        reg_write(SEL_CTRL, 8'h44);

        // Random transfers against bench-computed codes
        for (int t = 0; t < 8; t++) begin
            logic [6:0] a7;
            logic       dir;
            int         len;
            a7  = 7'($urandom_range(1, 119));
            dir = 1'($urandom);
            len = int'($urandom_range(1, 3));
            reg_write(SEL_OWN, {a7, 1'($urandom)});
            if (dir) begin
                b = 8'($urandom);
                reg_write(SEL_DATA, b);
            end
            bus_start();
            send_byte({a7, dir}, ack);
            check("R3 random addr ack", {7'd0, ack}, 8'h01);
            reg_read(SEL_STAT, rd); check("R7 random addr status", rd, exp_addr_code(dir, 1'b0));
            clear_flag();
            for (int k = 0; k < len; k++) begin
                if (dir) begin
                    logic last;
                    last = (k == len - 1);
                    recv_byte(~last, got);
                    check("R7 random tx byte", got, b);
                    reg_read(SEL_STAT, rd); check("R8 random tx status", rd, exp_tx_code(~last));
                    if (!last) begin
                        b = 8'($urandom);
                        reg_write(SEL_DATA, b);
                    end
                    clear_flag();
                end else begin
                    b = 8'($urandom);
                    send_byte(b, ack);
                    reg_read(SEL_STAT, rd); check("R6 random rx status", rd, 8'h80);
                    reg_read(SEL_DATA, rd); check("R6 random rx data", rd, b);
                    clear_flag();
                end
            end
            bus_stop();
            check("R9 random stop irq", {7'd0, irq}, dir ? 8'h00 : 8'h01);
            if (!dir) begin
                reg_read(SEL_STAT, rd); check("R9 random stop status", rd, 8'hA0);
                clear_flag();
            end
            reg_read(SEL_STAT, rd); check("R10 random idle status", rd, 8'hF8);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule